// File: doc/BRIEF.md
# Prioritised Interrupt Pend/Enable Controller

This block gathers a parameterised set of external interrupt lines and decides which of them the processor should take next. Each line has an enable bit, a pending bit, an active bit and a priority byte. Software manages these through a small word-addressed register port that uses separate set and clear words, so a read-modify-write is never needed. An asserted line always marks its interrupt pending. Only enabled pending interrupts are considered for service.

Every cycle a scan picks the enabled pending interrupt with the numerically lowest priority. Ties go to the lower interrupt number. A preemption request is raised when the processor is idle, or when the group part of the winner's priority is strictly lower than the group level of the interrupts already active. A 3-bit binary-point register chooses how many low priority bits form the subpriority. Subpriority bits only order interrupts for selection and never allow preemption.

The processor takes the requested interrupt with an acknowledge strobe carrying its number, and ends service with a completion strobe carrying the same number.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Word 0 (set-enable) and word 1 (clear-enable): writing a 1 bit sets or clears that line's enable, and writing a 0 bit leaves it unchanged. Both words read back the current enable vector, and bits above the line count read as 0.
- R2: Word 2 (set-pending) and word 3 (clear-pending) act in the same way on the pending vector, and both read it back. Clearing a pending bit returns that interrupt to inactive.
- R3: A high line sets its pending bit on the next clock whether or not it is enabled. A disabled pending interrupt is never requested, whatever its priority.
- R4: Word 8+k holds the priorities of interrupts 4k..4k+3, with interrupt n in byte n mod 4 (bits 8*(n mod 4)+7 down to 8*(n mod 4)). A value of 0 is the most urgent. Among enabled pending interrupts of equal priority, the lower number is selected.
- R5: Writing an interrupt number in bits 7:0 of word 5 sets that interrupt's pending bit. A number at or above the line count is ignored.
- R6: pend_vector is the selected interrupt number plus 16, or 0 when no enabled interrupt is pending. any_pend is high when any pending bit is set, enabled or not.
- R7: Word 6 bits 2:0 hold the binary point b. The group level is the priority with bits b..0 cleared. irq_req is high when an enabled interrupt is pending and either nothing is active or the selected group level is strictly below the lowest group level among the active interrupts. req_id names the selected interrupt.
- R8: An acknowledge of interrupt i clears pending bit i and sets active bit i on the next clock. A completion of interrupt i clears active bit i. Word 4 reads the active vector.
- R9: If a line is still high in the cycle its interrupt is acknowledged, the interrupt stays pending as well as becoming active.
- R10: Reset clears all enable, pending and active bits, all priorities and the binary point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | N_IRQ | Level-sensitive interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register word address for reads |
| rd_data | output | 32 | Combinational read data |
| ack_valid | input | 1 | Processor takes an interrupt |
| ack_id | input | ID_W | Number of the interrupt taken |
| done_valid | input | 1 | Processor completes an interrupt |
| done_id | input | ID_W | Number of the interrupt completed |
| irq_req | output | 1 | Preemption request |
| req_id | output | ID_W | Interrupt selected for service |
| pend_vector | output | 9 | Selected interrupt number plus 16, or 0 |
| any_pend | output | 1 | Some interrupt is pending |

## Verification
The bench builds the block with eight lines, so there are two priority words. This keeps the full-register behaviour visible: writes of all ones are masked to eight enable bits, and a software trigger with a number of 200 lies outside the line range. Eight lines are still enough to set up equal priorities on two lines, a nested active level, and a binary point of 6. That binary point folds two different priorities into the same group, so subpriority alone must not cause preemption.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int REG_W         = 32;
   localparam int A_ENA_SET     = 0;
   localparam int A_ENA_CLR     = 1;
   localparam int A_PND_SET     = 2;
   localparam int A_PND_CLR     = 3;
   localparam int A_ACTIVE      = 4;
   localparam int A_TRIGGER     = 5;
   localparam int A_BINPT       = 6;
   localparam int A_PRIO_BASE   = 8;
   localparam int VEC_OFFSET    = 16;
   localparam int VEC_W         = 9;
   localparam int BP_W          = 3;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int N_IRQ  = 32,
   parameter int PRIO_W = 8,
   parameter int ADDR_W = 5,
   parameter int ID_W   = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IRQ-1:0]        irq_line,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [REG_W-1:0]        wr_data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [REG_W-1:0]        rd_data,
   input  logic                    ack_valid,
   input  logic [ID_W-1:0]         ack_id,
   input  logic                    done_valid,
   input  logic [ID_W-1:0]         done_id,
   output logic [N_IRQ-1:0]        enable_q,
   output logic [N_IRQ-1:0]        pend_q,
   output logic [N_IRQ-1:0]        active_q,
   output logic [N_IRQ*PRIO_W-1:0] prio_flat,
   output logic [BP_W-1:0]         binpt_q
);
   localparam int WORDS = N_IRQ / 4;

   logic [PRIO_W-1:0] prio_q [N_IRQ];
   logic [N_IRQ-1:0]  set_en, clr_en, set_pnd, clr_pnd, trig_oh, ack_oh, done_oh;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int where);
      return a == ADDR_W'(where);
   endfunction

   always_comb begin
      set_en  = (wr_en && hit(wr_addr, A_ENA_SET)) ? wr_data[N_IRQ-1:0] : '0;
      clr_en  = (wr_en && hit(wr_addr, A_ENA_CLR)) ? wr_data[N_IRQ-1:0] : '0;
      set_pnd = (wr_en && hit(wr_addr, A_PND_SET)) ? wr_data[N_IRQ-1:0] : '0;
      clr_pnd = (wr_en && hit(wr_addr, A_PND_CLR)) ? wr_data[N_IRQ-1:0] : '0;
      trig_oh = '0;
      if (wr_en && hit(wr_addr, A_TRIGGER) && ({24'd0, wr_data[7:0]} < REG_W'(N_IRQ)))
         trig_oh[wr_data[ID_W-1:0]] = 1'b1;
      ack_oh  = '0;
      if (ack_valid) ack_oh[ack_id] = 1'b1;
      done_oh = '0;
      if (done_valid) done_oh[done_id] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         pend_q   <= '0;
         active_q <= '0;
         binpt_q  <= '0;
      end else begin
         enable_q <= (enable_q | set_en) & ~clr_en;
         pend_q   <= (pend_q & ~clr_pnd & ~ack_oh) | set_pnd | trig_oh | irq_line;
         active_q <= (active_q | ack_oh) & ~done_oh;
         if (wr_en && hit(wr_addr, A_BINPT))
            binpt_q <= wr_data[BP_W-1:0];
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < 4; b++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               prio_q[4*w+b] <= '0;
            else if (wr_en && hit(wr_addr, A_PRIO_BASE + w))
               prio_q[4*w+b] <= wr_data[8*b +: PRIO_W];
         end
         assign prio_flat[(4*w+b)*PRIO_W +: PRIO_W] = prio_q[4*w+b];
      end
   end

   always_comb begin
      rd_data = '0;
      if (hit(rd_addr, A_ENA_SET) || hit(rd_addr, A_ENA_CLR))
         rd_data[N_IRQ-1:0] = enable_q;
      else if (hit(rd_addr, A_PND_SET) || hit(rd_addr, A_PND_CLR))
         rd_data[N_IRQ-1:0] = pend_q;
      else if (hit(rd_addr, A_ACTIVE))
         rd_data[N_IRQ-1:0] = active_q;
      else if (hit(rd_addr, A_BINPT))
         rd_data[BP_W-1:0] = binpt_q;
      else begin
         for (int w = 0; w < WORDS; w++) begin
            if (hit(rd_addr, A_PRIO_BASE + w)) begin
               for (int b = 0; b < 4; b++)
                  rd_data[8*b +: PRIO_W] = prio_q[4*w+b];
            end
         end
      end
   end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int N  = 32,
   parameter int PW = 8,
   parameter int IW = 5
) (
   input  logic [N-1:0]    valid,
   input  logic [N*PW-1:0] prio_flat,
   input  logic [PW-1:0]   mask,
   output logic            found,
   output logic [IW-1:0]   idx,
   output logic [PW-1:0]   level
);
   logic [PW-1:0] key [N];

   for (genvar g = 0; g < N; g++) begin : g_key
      assign key[g] = prio_flat[g*PW +: PW] & mask;
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      level = '1;
      for (int i = 0; i < N; i++) begin
         if (valid[i] && (!found || key[i] < level)) begin
            found = 1'b1;
            idx   = IW'(i);
            level = key[i];
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int N_IRQ  = 32,
   parameter int PRIO_W = 8,
   parameter int ADDR_W = 5,
   localparam int ID_W  = $clog2(N_IRQ)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_IRQ-1:0]    irq_line,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [REG_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [REG_W-1:0]    rd_data,
   input  logic                ack_valid,
   input  logic [ID_W-1:0]     ack_id,
   input  logic                done_valid,
   input  logic [ID_W-1:0]     done_id,
   output logic                irq_req,
   output logic [ID_W-1:0]     req_id,
   output logic [VEC_W-1:0]    pend_vector,
   output logic                any_pend
);
   if (N_IRQ < 4 || N_IRQ > REG_W || (N_IRQ % 4) != 0) begin : g_bad_lines
      $error("N_IRQ must be a multiple of 4 between 4 and 32");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must be between 1 and 8");
   end
   if ((1 << ADDR_W) < A_PRIO_BASE + N_IRQ / 4) begin : g_bad_addr
      $error("ADDR_W too narrow for the priority words");
   end

   logic [N_IRQ-1:0]        enable_q, pend_q, active_q;
   logic [N_IRQ*PRIO_W-1:0] prio_flat;
   logic [BP_W-1:0]         binpt_q;
   logic [PRIO_W-1:0]       grp_mask;
   logic                    best_found, act_found;
   logic [ID_W-1:0]         best_idx, act_idx;
   logic [PRIO_W-1:0]       best_prio, act_grp;

   irqc_regs #(
      .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ack_valid(ack_valid), .ack_id(ack_id),
      .done_valid(done_valid), .done_id(done_id),
      .enable_q(enable_q), .pend_q(pend_q), .active_q(active_q),
      .prio_flat(prio_flat), .binpt_q(binpt_q)
   );

   assign grp_mask = {PRIO_W{1'b1}} << ({1'b0, binpt_q} + 4'd1);

   irqc_pick #(.N(N_IRQ), .PW(PRIO_W), .IW(ID_W)) u_best (
      .valid(enable_q & pend_q), .prio_flat(prio_flat), .mask({PRIO_W{1'b1}}),
      .found(best_found), .idx(best_idx), .level(best_prio)
   );

   irqc_pick #(.N(N_IRQ), .PW(PRIO_W), .IW(ID_W)) u_level (
      .valid(active_q), .prio_flat(prio_flat), .mask(grp_mask),
      .found(act_found), .idx(act_idx), .level(act_grp)
   );

   assign irq_req     = best_found && (!act_found || ((best_prio & grp_mask) < act_grp));
   assign req_id      = best_idx;
   assign pend_vector = best_found ? (VEC_W'(best_idx) + VEC_W'(VEC_OFFSET)) : '0;
   assign any_pend    = |pend_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int N_IRQ = 32,
   parameter int ID_W  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_IRQ-1:0] irq_line,
   input logic             ack_valid,
   input logic [ID_W-1:0]  ack_id,
   input logic             done_valid,
   input logic [ID_W-1:0]  done_id,
   input logic             irq_req,
   input logic [ID_W-1:0]  req_id,
   input logic [8:0]       pend_vector,
   input logic             any_pend,
   input logic [N_IRQ-1:0] enable_q,
   input logic [N_IRQ-1:0] pend_q,
   input logic [N_IRQ-1:0] active_q
);
   a_r3_req_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (enable_q[req_id] && pend_q[req_id]));

   a_r3_line_pends: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_line != '0) |=> ((pend_q & $past(irq_line)) == $past(irq_line)));

   a_r6_vector_implies_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vector != '0) |-> any_pend);

   a_r8_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !(done_valid && done_id == ack_id)) |=> active_q[$past(ack_id)]);

   a_r8_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !active_q[$past(done_id)]);

   a_r9_held_line_repends: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && irq_line[ack_id]) |=> pend_q[$past(ack_id)]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
   .ack_valid(ack_valid), .ack_id(ack_id),
   .done_valid(done_valid), .done_id(done_id),
   .irq_req(irq_req), .req_id(req_id), .pend_vector(pend_vector),
   .any_pend(any_pend), .enable_q(enable_q), .pend_q(pend_q), .active_q(active_q)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
   localparam int N  = 8;
   localparam int IW = 3;
   localparam int NT = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_line = '0;
   logic          wr_en = 1'b0;
   logic [4:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [4:0]    rd_addr = '0;
   logic [31:0]   rd_data;
   logic          ack_valid = 1'b0;
   logic [IW-1:0] ack_id = '0;
   logic          done_valid = 1'b0;
   logic [IW-1:0] done_id = '0;
   logic          irq_req;
   logic [IW-1:0] req_id;
   logic [8:0]    pend_vector;
   logic          any_pend;

   int total = 0;
   int bad = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   prio_irq_ctrl #(.N_IRQ(N)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .ack_valid(ack_valid), .ack_id(ack_id),
      .done_valid(done_valid), .done_id(done_id),
      .irq_req(irq_req), .req_id(req_id),
      .pend_vector(pend_vector), .any_pend(any_pend)
   );

   // entry = {is_write, word address, data}; a read entry compares rd_data to data
   localparam logic [37:0] TBL [NT] = '{
      {1'b0, 5'd0, 32'h0},        {1'b0, 5'd2, 32'h0},
      {1'b1, 5'd0, 32'h0F},       {1'b0, 5'd1, 32'h0F},
      {1'b1, 5'd0, 32'h0},        {1'b0, 5'd0, 32'h0F},
      {1'b1, 5'd1, 32'h03},       {1'b0, 5'd0, 32'h0C},
      {1'b1, 5'd0, 32'hFFFFFFFF}, {1'b0, 5'd0, 32'hFF},
      {1'b1, 5'd2, 32'h81},       {1'b0, 5'd2, 32'h81},
      {1'b1, 5'd3, 32'h01},       {1'b0, 5'd3, 32'h80},
      {1'b1, 5'd5, 32'd5},        {1'b0, 5'd2, 32'hA0},
      {1'b1, 5'd5, 32'd200},      {1'b0, 5'd2, 32'hA0},
      {1'b1, 5'd8, 32'h40302010}, {1'b0, 5'd8, 32'h40302010},
      {1'b1, 5'd6, 32'hFF},       {1'b0, 5'd6, 32'd7},
      {1'b1, 5'd3, 32'hFF},       {1'b0, 5'd2, 32'h0}
   };

   function automatic string tag_of(input int idx, input logic [4:0] a);
      if (idx < 2) return "R10";
      case (a)
         5'd0, 5'd1: return "R1";
         5'd2, 5'd3: return "R2";
         5'd5:       return "R5";
         5'd6:       return "R7";
         default:    return "R4";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NT; i++) begin
         if (TBL[i][37]) wr(TBL[i][36:32], TBL[i][31:0]);
         else            rd_chk(tag_of(i, TBL[i][36:32]), TBL[i][36:32], TBL[i][31:0]);
      end

      do_reset();
      #1;
      chk("R10 irq_req", {31'd0, irq_req}, 32'd0);
      chk("R10 any_pend", {31'd0, any_pend}, 32'd0);
      chk("R10 pend_vector", {23'd0, pend_vector}, 32'd0);

      // R3: disabled line still pends but is not requested
      @(negedge clk); irq_line = 8'h04;
      @(negedge clk); irq_line = 8'h00;
      rd_chk("R3 pending", 5'd2, 32'h04);
      chk("R3 no request", {31'd0, irq_req}, 32'd0);
      chk("R6 any_pend", {31'd0, any_pend}, 32'd1);
      chk("R6 vector none", {23'd0, pend_vector}, 32'd0);

      wr(5'd0, 32'h04);
      #1;
      chk("R7 idle request", {31'd0, irq_req}, 32'd1);
      chk("R7 req_id", {29'd0, req_id}, 32'd2);
      chk("R6 vector", {23'd0, pend_vector}, 32'd18);

      // R4: priorities p1=0x40 p2=0x80 p3=0x20 p6=0x40
      wr(5'd8, 32'h20804000);
      wr(5'd9, 32'h00400000);
      wr(5'd0, 32'h40);
      wr(5'd2, 32'h40);
      #1;
      chk("R4 lower value wins", {29'd0, req_id}, 32'd6);
      wr(5'd0, 32'h02);
      wr(5'd2, 32'h02);
      #1;
      chk("R4 tie lower index", {29'd0, req_id}, 32'd1);

      // R8: acknowledge interrupt 1
      @(negedge clk); ack_valid = 1'b1; ack_id = 3'd1;
      @(negedge clk); ack_valid = 1'b0;
      rd_chk("R8 pending cleared", 5'd3, 32'h44);
      rd_chk("R8 active set", 5'd4, 32'h02);
      chk("R7 equal group no preempt", {31'd0, irq_req}, 32'd0);
      chk("R6 vector while active", {23'd0, pend_vector}, 32'd22);

      wr(5'd0, 32'h08);
      wr(5'd2, 32'h08);
      #1;
      chk("R7 strict preempt", {31'd0, irq_req}, 32'd1);
      chk("R7 preempt id", {29'd0, req_id}, 32'd3);

      wr(5'd6, 32'd6);
      #1;
      chk("R7 subpriority only", {31'd0, irq_req}, 32'd0);

      @(negedge clk); done_valid = 1'b1; done_id = 3'd1;
      @(negedge clk); done_valid = 1'b0;
      rd_chk("R8 active cleared", 5'd4, 32'h00);
      chk("R8 request after done", {31'd0, irq_req}, 32'd1);
      chk("R8 id after done", {29'd0, req_id}, 32'd3);

      // R9: line held high through acknowledge
      @(negedge clk); ack_valid = 1'b1; ack_id = 3'd3; irq_line = 8'h08;
      @(negedge clk); ack_valid = 1'b0; irq_line = 8'h00;
      rd_chk("R9 still pending", 5'd2, 32'h4C);
      rd_chk("R9 active", 5'd4, 32'h08);

      do_reset();
      rd_chk("R10 enables", 5'd0, 32'h0);
      rd_chk("R10 binary point", 5'd6, 32'h0);
      rd_chk("R10 priorities", 5'd8, 32'h0);
      rd_chk("R10 active", 5'd4, 32'h0);

      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule